// File: doc/BRIEF.md
# Battery-Gauge Register Slave on a Two-Wire Bus

This block is the host-facing side of a battery charge monitor. It answers a two-wire serial bus (I2C) at one fixed 7-bit address. Behind that address sit eight byte-wide registers: a status byte, a control byte, and three 16-bit values (accumulated charge, upper charge limit, lower charge limit), each split into a high and a low byte. SCL and SDA enter as ordinary inputs sampled by the system clock. The block drives SDA only by pulling it low through an enable output.

The neighbouring logic drives the other inputs. A coulomb accumulator may overwrite the charge value. Five condition levels (counter saturation, above the upper limit, below the lower limit, low battery voltage, supply dropout) set sticky flags in the status byte. A host read of the status byte clears each flag whose condition has gone away. The control byte is exported whole, so the analog side can pick its voltage threshold, prescaler and shutdown from it. Its alert-pin field is also decoded into two enables.

A host write sends a command byte that loads a 3-bit register pointer, followed by data bytes. A host read sets the pointer the same way, then issues a repeated START with the read bit. In both cases the pointer steps forward after each byte.

Top module: `gauge_i2c_slave`

## Requirements
- R1: Only the address byte 1100100 plus R/W bit is acknowledged. After any other address the slave leaves SDA released for that byte and for every later byte until the next START, and no register changes.
- R2: After reset the register values are: control 3Ch, charge 7FFFh, upper limit FFFFh, lower limit 0000h. A status read returns 80h.
- R3: In a write, the low three bits of the command byte load the pointer; the upper five bits are ignored. Each following data byte is acknowledged and stored at the pointer. The pointer then increments and wraps from 7 to 0. The byte map is: 0 status, 1 control, 2 charge high, 3 charge low, 4 upper high, 5 upper low, 6 lower high, 7 lower low.
- R4: A data byte written to pointer 0 (status) is acknowledged and discarded, and the pointer still advances.
- R5: In a read the slave sends the byte at the pointer, MSB first. A master ACK advances the pointer and starts the next byte. A master NACK ends the transfer without advancing, so a later read that sends only address+R starts from that same register.
- R6: Status bit 7 reads 1, and bits 6 and 4 read 0. Input cond_i[4:0] = {saturation, above-upper, below-lower, low-battery, dropout} sets, one cycle later, sticky bits 5, 3, 2, 1 and 0 respectively.
- R7: A sticky bit clears only when the status byte is loaded for transmission and its condition is low at that moment. Otherwise it holds.
- R8: When charge high and charge low are read in one sequential read, the low byte comes from the same charge value as the high byte, even if the accumulator updates the charge between them.
- R9: A pulse on chg_upd_i loads chg_val_i into the charge value on the next clock.
- R10: Control bit 2 drives alert_en_o and control bit 1 drives cc_en_o. So 10 gives alert output, 01 gives charge-complete input, 00 gives neither, and 11 enables both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| cond_i | input | 5 | Flag conditions {saturation, above-upper, below-lower, low-battery, dropout} |
| chg_upd_i | input | 1 | Accumulator load strobe for the charge value |
| chg_val_i | input | 16 | Charge value loaded by chg_upd_i |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ctrl_o | output | 8 | Control byte |
| charge_o | output | 16 | Accumulated charge value |
| thr_hi_o | output | 16 | Upper charge limit |
| thr_lo_o | output | 16 | Lower charge limit |
| alert_en_o | output | 1 | Alert pin acts as an output |
| cc_en_o | output | 1 | Alert pin acts as a charge-complete input |

## Verification
The hardest case to reach is an accumulator update that lands between the two bytes of one charge read. The stimulus runs the master's receive of the high byte in parallel with a strobe on chg_upd_i, timed into the middle of that byte. It then checks that the low byte still belongs to the old value and that a fresh read returns the new one.

Flag clearing is driven by holding one condition high across a status read while the others drop. Pointer wrap-around is reached by writing and reading runs of bytes that cross from register 7 into the status byte.

// File: rtl/gauge_pkg.sv
package gauge_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PTR_W   = 3;
    localparam int unsigned WORD_W  = 2 * BYTE_W;
    localparam int unsigned FLAG_W  = 5;
    localparam int unsigned ALERT_BIT = 2;
    localparam int unsigned CC_BIT    = 1;

    localparam logic [PTR_W-1:0] P_STATUS = 3'd0;
    localparam logic [PTR_W-1:0] P_CTRL   = 3'd1;
    localparam logic [PTR_W-1:0] P_CHG_H  = 3'd2;
    localparam logic [PTR_W-1:0] P_CHG_L  = 3'd3;
    localparam logic [PTR_W-1:0] P_UPR_H  = 3'd4;
    localparam logic [PTR_W-1:0] P_UPR_L  = 3'd5;
    localparam logic [PTR_W-1:0] P_LWR_H  = 3'd6;
    localparam logic [PTR_W-1:0] P_LWR_L  = 3'd7;

    localparam logic [BYTE_W-1:0] CTRL_RST = 8'h3C;
    localparam logic [WORD_W-1:0] CHG_RST  = 16'h7FFF;
    localparam logic [WORD_W-1:0] UPR_RST  = 16'hFFFF;
    localparam logic [WORD_W-1:0] LWR_RST  = 16'h0000;

    typedef enum logic [3:0] {
        PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_CMD, PH_CMD_ACK,
        PH_WR, PH_WR_ACK, PH_RD, PH_RD_ACK
    } phase_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [WORD_W-1:0] chg;
        logic [WORD_W-1:0] upr;
        logic [WORD_W-1:0] lwr;
    } store_t;

    typedef struct packed {
        phase_t            ph;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [PTR_W-1:0]  ptr;
        logic              rw;
        logic              mack;
        logic              oe;
        logic [BYTE_W-1:0] snap;
        logic              snap_vld;
    } xfer_t;

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] prev_d, prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe_d, pipe_q;
        always_comb pipe_d = {pipe_q[SYNC_STAGES-2:0], raw[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end
        assign lvl[g] = pipe_q[SYNC_STAGES-1];
    end

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= prev_d;
    end

    assign scl_s     = lvl[0];
    assign sda_s     = lvl[1];
    assign scl_rise  = lvl[0] & ~prev_q[0];
    assign scl_fall  = ~lvl[0] & prev_q[0];
    assign bus_start = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
    assign bus_stop  = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];

endmodule

// File: rtl/gauge_status_sticky.sv
module gauge_status_sticky
    import gauge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] cond_i,
    input  logic              clr_i,
    output logic [FLAG_W-1:0] flags_o
);

    logic [FLAG_W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_i) flags_d = '0;
        flags_d = flags_d | cond_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    assert_cond_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i != '0) |=> ((flags_o & $past(cond_i)) == $past(cond_i)))
        else $error("condition did not set its flag");

    assert_clear_gone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((flags_o & ~$past(cond_i)) == '0))
        else $error("flag survived a read after its condition dropped");

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)))
        else $error("flag cleared without a status read");

endmodule

// File: rtl/gauge_reg_store.sv
module gauge_reg_store
    import gauge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_ptr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              chg_upd_i,
    input  logic [WORD_W-1:0] chg_val_i,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] charge_o,
    output logic [WORD_W-1:0] thr_hi_o,
    output logic [WORD_W-1:0] thr_lo_o
);

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (chg_upd_i) s_d.chg = chg_val_i;
        if (wr_en_i) begin
            case (wr_ptr_i)
                P_CTRL:  s_d.ctrl           = wr_data_i;
                P_CHG_H: s_d.chg[15:8]      = wr_data_i;
                P_CHG_L: s_d.chg[7:0]       = wr_data_i;
                P_UPR_H: s_d.upr[15:8]      = wr_data_i;
                P_UPR_L: s_d.upr[7:0]       = wr_data_i;
                P_LWR_H: s_d.lwr[15:8]      = wr_data_i;
                P_LWR_L: s_d.lwr[7:0]       = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ctrl: CTRL_RST, chg: CHG_RST, upr: UPR_RST, lwr: LWR_RST};
        else        s_q <= s_d;
    end

    assign ctrl_o   = s_q.ctrl;
    assign charge_o = s_q.chg;
    assign thr_hi_o = s_q.upr;
    assign thr_lo_o = s_q.lwr;

    assert_reset_vals_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_o == CTRL_RST && charge_o == CHG_RST
                          && thr_hi_o == UPR_RST && thr_lo_o == LWR_RST))
        else $error("register values wrong after reset");

    assert_acc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_upd_i && !(wr_en_i && (wr_ptr_i == P_CHG_H || wr_ptr_i == P_CHG_L)))
        |=> (charge_o == $past(chg_val_i)))
        else $error("accumulator load not taken");

endmodule

// File: rtl/gauge_i2c_slave.sv
module gauge_i2c_slave
    import gauge_pkg::*;
#(
    parameter logic [6:0]  SLAVE_ADDR  = 7'b1100100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [FLAG_W-1:0] cond_i,
    input  logic              chg_upd_i,
    input  logic [WORD_W-1:0] chg_val_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [WORD_W-1:0] charge_o,
    output logic [WORD_W-1:0] thr_hi_o,
    output logic [WORD_W-1:0] thr_lo_o,
    output logic              alert_en_o,
    output logic              cc_en_o
);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [FLAG_W-1:0] flags;
    logic              clr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_ptr;
    logic [BYTE_W-1:0] wr_data;
    logic [PTR_W-1:0]  lp;
    logic [BYTE_W-1:0] lbyte;
    xfer_t x_d, x_q;

    i2c_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    gauge_status_sticky u_flags (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .clr_i(clr), .flags_o(flags)
    );

    gauge_reg_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr),
        .wr_data_i(wr_data), .chg_upd_i(chg_upd_i), .chg_val_i(chg_val_i),
        .ctrl_o(ctrl_o), .charge_o(charge_o), .thr_hi_o(thr_hi_o), .thr_lo_o(thr_lo_o)
    );

    // byte that a transmit load would latch now
    always_comb begin
        lp = (x_q.ph == PH_RD_ACK) ? x_q.ptr + 3'd1 : x_q.ptr;
        case (lp)
            P_STATUS: lbyte = {1'b1, 1'b0, flags[4], 1'b0, flags[3:0]};
            P_CTRL:   lbyte = ctrl_o;
            P_CHG_H:  lbyte = charge_o[15:8];
            P_CHG_L:  lbyte = x_q.snap_vld ? x_q.snap : charge_o[7:0];
            P_UPR_H:  lbyte = thr_hi_o[15:8];
            P_UPR_L:  lbyte = thr_hi_o[7:0];
            P_LWR_H:  lbyte = thr_lo_o[15:8];
            default:  lbyte = thr_lo_o[7:0];
        endcase
    end

    always_comb begin
        x_d     = x_q;
        wr_en   = 1'b0;
        wr_ptr  = x_q.ptr;
        wr_data = x_q.sh;
        clr     = 1'b0;
        if (bus_stop) begin
            x_d.ph = PH_IDLE;
            x_d.oe = 1'b0;
            x_d.snap_vld = 1'b0;
        end else if (bus_start) begin
            x_d.ph  = PH_ADDR;
            x_d.cnt = '0;
            x_d.oe  = 1'b0;
            x_d.snap_vld = 1'b0;
        end else begin
            case (x_q.ph)
                PH_ADDR, PH_CMD, PH_WR: begin
                    if (scl_rise) begin
                        x_d.sh  = {x_q.sh[6:0], sda_s};
                        x_d.cnt = x_q.cnt + 4'd1;
                    end
                    if (scl_fall && x_q.cnt == 4'd8) begin
                        x_d.cnt = '0;
                        x_d.oe  = 1'b1;
                        if (x_q.ph == PH_ADDR) begin
                            x_d.rw = x_q.sh[0];
                            x_d.ph = PH_ADDR_ACK;
                            if (x_q.sh[7:1] != SLAVE_ADDR) begin
                                x_d.ph = PH_IDLE;
                                x_d.oe = 1'b0;
                            end
                        end else if (x_q.ph == PH_CMD) begin
                            x_d.ptr = x_q.sh[PTR_W-1:0];
                            x_d.ph  = PH_CMD_ACK;
                            x_d.snap_vld = 1'b0;
                        end else begin
                            wr_en   = (x_q.ptr != P_STATUS);
                            x_d.ptr = x_q.ptr + 3'd1;
                            x_d.ph  = PH_WR_ACK;
                            x_d.snap_vld = 1'b0;
                        end
                    end
                end
                PH_CMD_ACK, PH_WR_ACK: begin
                    if (scl_fall) begin
                        x_d.oe = 1'b0;
                        x_d.ph = PH_WR;
                    end
                end
                PH_RD: begin
                    if (scl_fall) begin
                        if (x_q.cnt == 4'd8) begin
                            x_d.oe = 1'b0;
                            x_d.ph = PH_RD_ACK;
                        end else begin
                            x_d.tx  = {x_q.tx[6:0], 1'b0};
                            x_d.oe  = ~x_q.tx[6];
                            x_d.cnt = x_q.cnt + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
            if (x_q.ph == PH_RD_ACK && scl_rise) x_d.mack = ~sda_s;
            if (scl_fall && (x_q.ph == PH_ADDR_ACK || x_q.ph == PH_RD_ACK)) begin
                if (x_q.ph == PH_ADDR_ACK && !x_q.rw) begin
                    x_d.oe = 1'b0;
                    x_d.ph = PH_CMD;
                end else if (x_q.ph == PH_RD_ACK && !x_q.mack) begin
                    x_d.ph = PH_IDLE;
                end else begin
                    x_d.ptr      = lp;
                    x_d.tx       = lbyte;
                    x_d.oe       = ~lbyte[7];
                    x_d.cnt      = 4'd1;
                    x_d.ph       = PH_RD;
                    x_d.snap     = charge_o[7:0];
                    x_d.snap_vld = (lp == P_CHG_H);
                    clr          = (lp == P_STATUS);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '{ph: PH_IDLE, cnt: '0, sh: '0, tx: '0, ptr: '0, rw: 1'b0,
                             mack: 1'b0, oe: 1'b0, snap: '0, snap_vld: 1'b0};
        else        x_q <= x_d;
    end

    assign sda_oe_o   = x_q.oe;
    assign alert_en_o = ctrl_o[ALERT_BIT];
    assign cc_en_o    = ctrl_o[CC_BIT];

    assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q.ph == PH_ADDR && scl_fall && x_q.cnt == 4'd8 && x_q.sh[7:1] != SLAVE_ADDR)
        |=> !sda_oe_o)
        else $error("slave answered a foreign address");

    assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_s)
        else $error("SDA drive changed while SCL high");

endmodule

// File: tb/test_gauge_i2c_slave.sv
module test_gauge_i2c_slave;

    localparam int Q = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic [4:0]  cond = '0;
    logic        chg_upd = 1'b0;
    logic [15:0] chg_val = '0;
    logic        sda_oe;
    logic [7:0]  ctrl_o;
    logic [15:0] charge_o, thr_hi_o, thr_lo_o;
    logic        alert_en_o, cc_en_o;

    assign sda_line = sda_m & ~sda_oe;

    gauge_i2c_slave i_gauge_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .cond_i(cond), .chg_upd_i(chg_upd), .chg_val_i(chg_val),
        .sda_oe_o(sda_oe), .ctrl_o(ctrl_o), .charge_o(charge_o),
        .thr_hi_o(thr_hi_o), .thr_lo_o(thr_lo_o),
        .alert_en_o(alert_en_o), .cc_en_o(cc_en_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit hold  = 1'b1;
    logic [7:0] mreg [0:7];
    logic [4:0] mflag = '0;
    logic [2:0] mptr = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    function automatic logic [7:0] expv(input logic [2:0] p);
        if (p == 3'd0) return {1'b1, 1'b0, mflag[4], 1'b0, mflag[3:0]};
        return mreg[p];
    endfunction

    // reference compare on every clock while the model is settled
    always @(negedge clk) begin
        if (rst_n && !hold) begin
            check("R3 control", ctrl_o, mreg[1]);
            check("R9 charge", charge_o, {mreg[2], mreg[3]});
            check("R3 upper", thr_hi_o, {mreg[4], mreg[5]});
            check("R3 lower", thr_lo_o, {mreg[6], mreg[7]});
            check("R10 alert_en", alert_en_o, mreg[1][2]);
            check("R10 cc_en", cc_en_o, mreg[1][1]);
        end
    end

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
        end
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; acked = !sda_line; wq; scl_m = 1'b0; wq;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq; scl_m = 1'b1; wq; b[i] = sda_line; wq; scl_m = 1'b0; wq;
        end
        sda_m = !give_ack; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq; sda_m = 1'b1;
    endtask

    task automatic wr_regs(input logic [7:0] cmd, input logic [7:0] data [$], input string tag);
        bit a;
        logic [2:0] p;
        hold = 1'b1;
        bus_start;
        send_byte(8'hC8, a); check({tag, " R1 address ack"}, a, 1);
        send_byte(cmd, a);   check({tag, " R3 command ack"}, a, 1);
        p = cmd[2:0];
        foreach (data[k]) begin
            send_byte(data[k], a); check({tag, " R3 data ack"}, a, 1);
            if (p != 3'd0) mreg[p] = data[k];
            p = p + 3'd1;
        end
        mptr = p;
        bus_stop;
        wq;
        hold = 1'b0;
    endtask

    task automatic rd_body(input int n, input string tag);
        bit a;
        logic [7:0] b;
        bus_start;
        send_byte(8'hC9, a); check({tag, " R5 read address ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            check(tag, b, expv(mptr));
            if (mptr == 3'd0) mflag = mflag & cond;
            if (i < n - 1) mptr = mptr + 3'd1;
        end
        bus_stop;
    endtask

    task automatic rd_at(input logic [7:0] cmd, input int n, input string tag);
        bit a;
        bus_start;
        send_byte(8'hC8, a); check({tag, " R1 address ack"}, a, 1);
        send_byte(cmd, a);   check({tag, " R3 command ack"}, a, 1);
        mptr = cmd[2:0];
        rd_body(n, tag);
    endtask

    task automatic set_cond(input logic [4:0] v);
        cond = v;
        mflag = mflag | v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] b0, b1;
        mreg[0] = 8'h00; mreg[1] = 8'h3C; mreg[2] = 8'h7F; mreg[3] = 8'hFF;
        mreg[4] = 8'hFF; mreg[5] = 8'hFF; mreg[6] = 8'h00; mreg[7] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 control reset", ctrl_o, 8'h3C);
        check("R2 charge reset", charge_o, 16'h7FFF);
        check("R2 upper reset", thr_hi_o, 16'hFFFF);
        check("R2 lower reset", thr_lo_o, 16'h0000);
        check("R2 sda released", sda_oe, 0);
        hold = 1'b0;
        rd_at(8'h00, 1, "R2 status reset");

        // alert pin modes
        wr_regs(8'h01, '{8'h3A}, "R10 mode 01");
        check("R10 mode 01 cc", {alert_en_o, cc_en_o}, 2'b01);
        wr_regs(8'h01, '{8'h38}, "R10 mode 00");
        check("R10 mode 00", {alert_en_o, cc_en_o}, 2'b00);
        wr_regs(8'h01, '{8'h3E}, "R10 mode 11");
        check("R10 mode 11", {alert_en_o, cc_en_o}, 2'b11);
        wr_regs(8'hF9, '{8'h3C}, "R3 upper command bits ignored");
        check("R10 mode 10", {alert_en_o, cc_en_o}, 2'b10);

        // multi-byte writes and read-back
        wr_regs(8'h02, '{8'h12, 8'h34}, "R3 charge write");
        wr_regs(8'h04, '{8'hAB, 8'hCD, 8'h01, 8'h02}, "R3 limits write");
        rd_at(8'h01, 7, "R5 sequential read");

        // wrap and status write discard
        wr_regs(8'h07, '{8'h5A, 8'h77, 8'h1C}, "R4 wrap write");
        rd_at(8'h06, 4, "R4 wrap read");

        // NACK does not advance
        rd_at(8'h04, 1, "R5 nack read");
        rd_body(1, "R5 re-read after nack");
        rd_body(3, "R5 continue read");

        // sticky flags
        set_cond(5'b10101);
        set_cond(5'b00001);
        rd_at(8'h00, 1, "R6 status flags");
        rd_body(1, "R7 flag kept while condition high");
        set_cond(5'b00000);
        rd_body(1, "R7 flag still sticky");
        rd_body(1, "R7 flags cleared");
        set_cond(5'b01010);
        set_cond(5'b00000);
        rd_at(8'h00, 2, "R6 upper/battery flags");

        // accumulator load
        hold = 1'b1;
        chg_upd = 1'b1; chg_val = 16'hC3E1;
        @(negedge clk);
        chg_upd = 1'b0;
        mreg[2] = 8'hC3; mreg[3] = 8'hE1;
        @(negedge clk);
        hold = 1'b0;
        check("R9 charge loaded", charge_o, 16'hC3E1);

        // update between the two charge bytes
        hold = 1'b1;
        bus_start;
        send_byte(8'hC8, a); check("R8 address ack", a, 1);
        send_byte(8'h02, a); check("R8 command ack", a, 1);
        bus_start;
        send_byte(8'hC9, a); check("R8 read address ack", a, 1);
        fork
            recv_byte(1'b1, b0);
            begin
                repeat (40) @(negedge clk);
                chg_upd = 1'b1; chg_val = 16'h5AA5;
                @(negedge clk);
                chg_upd = 1'b0;
            end
        join
        recv_byte(1'b0, b1);
        bus_stop;
        check("R8 high byte", b0, 8'hC3);
        check("R8 low byte from same value", b1, 8'hE1);
        mreg[2] = 8'h5A; mreg[3] = 8'hA5;
        wq;
        hold = 1'b0;
        rd_at(8'h02, 2, "R8 fresh read");

        // foreign address
        hold = 1'b1;
        bus_start;
        send_byte(8'hCA, a); check("R1 foreign address nack", a, 0);
        send_byte(8'h01, a); check("R1 later byte nack", a, 0);
        send_byte(8'h55, a); check("R1 data byte nack", a, 0);
        bus_stop;
        wq;
        hold = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 control untouched", ctrl_o, mreg[1]);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule